// File: doc/BRIEF.md
# Receive descriptor ring writer

This block moves received frames from a byte stream into memory buffers owned by a ring of receive descriptors. Each descriptor is 32 bytes long. Word 0 holds the ownership flag and, after write-back, the status. Word 1 holds two buffer sizes and the wrap flag. Words 2 and 3 hold two buffer addresses. Software arms a descriptor by writing word 0 with only bit 31 set. The engine fills the buffers and then writes word 0 back with bit 31 clear, which returns the descriptor to software.

A frame larger than one descriptor's two buffers is split over several descriptors, with first- and last-segment flags marking the pieces. The engine reads the next descriptor's word 0 before it gives up the current one. If that next descriptor is not armed, the frame is cut short and closed with an overflow flag. If the current descriptor is not armed when a frame arrives, the engine is suspended: it consumes and discards whole frames and counts them as missed. A poll-demand strobe makes it read word 0 again. The start input runs or parks the engine, and a new start always begins at the ring base.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset, mem_req, in_ready and missed_count are all 0. While start is low nothing happens. When start rises, the first memory access is a read of word 0 at ring_base.
- R2: Frame bytes are packed little-endian, so byte k of a word sits in bits 8k+7:8k. Words are written one after another from the buffer-1 address (word 2). The last, partial word of a segment has zeros in its unused upper bytes.
- R3: Buffer 1 holds the number of bytes given in word 1 bits 12:0. The bytes that follow go to the buffer-2 address (word 3), up to the size in word 1 bits 28:16. A segment never holds more than the sum of the two sizes.
- R4: The status write-back to word 0 has these fields: bit 31 (ownership) is 0; bits 29:16 hold the length; bit 9 is first segment; bit 8 is last segment; bit 5 is the frame-type marker taken from in_fcs_incl; bit 1 is CRC error; bit 11 is overflow; bit 15 is the error summary, the OR of bits 1 and 11. All other bits are 0. It is written only after every data word of that segment.
- R5: When a segment is full and the frame goes on, the engine reads the next descriptor's word 0. If bit 31 is set there, the current descriptor is written back with length 0 and last segment 0, and the frame continues in the next descriptor with first segment 0. Only the last segment carries the whole frame length.
- R6: If the next descriptor's bit 31 is clear at that point, the rest of the frame is consumed and discarded. The current descriptor is then closed with last segment, overflow and error summary set, and with the stored byte count as its length.
- R7: After each write-back the engine moves 32 bytes on. If word 1 bit 15 was set in the descriptor just finished, it returns to ring_base instead.
- R8: If word 0 bit 31 is clear when a descriptor is fetched, the engine suspends. Frames that arrive are consumed and dropped whole, nothing is written to memory, and missed_count rises by one for each dropped frame.
- R9: A poll_demand strobe makes a suspended engine fetch word 0 again. If the strobe arrives in the middle of a dropped frame, that frame is still dropped whole, and the fetch follows its last byte.
- R10: A memory request, with its address, direction and write data, is held unchanged until mem_ack.
- R11: If start is low while the engine waits for a new frame, it parks: in_ready and mem_req stay 0. The next start fetches from ring_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run (1) or park at a frame boundary (0) |
| ring_base | input | AW | Byte address of the first descriptor |
| poll_demand | input | 1 | One-cycle strobe: fetch the current descriptor again |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_fcs_incl | input | 1 | Frame-type marker (length includes the check sequence), sampled with the last byte |
| in_ready | output | 1 | Stream byte accepted when in_valid and in_ready are both 1 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current access |
| missed_count | output | CW | Frames dropped while suspended (wraps) |

## Verification
A wrong segment count or buffer pointer shows up in the bench's memory model: bytes land at the wrong address or past the buffer 1 limit, and the misplaced word is visible as soon as the frame's status is written. A wrong flag or length register is caught at the moment of the word-0 write-back, because the scoreboard compares every status write against the expected address and value. A wrong ownership decision appears either as a status write the bench did not expect, or as missed_count disagreeing with the count of dropped frames a few cycles after the frame ends. A lost request hold is flagged in the very next stalled cycle.

// File: rtl/rxdr_pkg.sv
// Shared constants and types for the receive descriptor ring writer.
// Assumes 32-bit memory words and 32-byte descriptors.
package rxdr_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_BYTES = 32;

    // word 0 fields
    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 14;
    localparam int ESUM_BIT  = 15;
    localparam int OVF_BIT   = 11;
    localparam int FSEG_BIT  = 9;
    localparam int LSEG_BIT  = 8;
    localparam int FTYPE_BIT = 5;
    localparam int CRC_BIT   = 1;

    // word 1 fields
    localparam int SZ_W     = 13;
    localparam int SZ1_LSB  = 0;
    localparam int SZ2_LSB  = 16;
    localparam int WRAP_BIT = 15;
    localparam int SEG_W    = SZ_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_SUSP,
        ST_RECV, ST_WRD, ST_PEEK, ST_DRAIN, ST_WB
    } rxdr_state_e;

    typedef struct packed {
        logic             first;
        logic             last;
        logic             ovf;
        logic             crc;
        logic             ftype;
        logic [LEN_W-1:0] len;
    } rxdr_stat_t;
endpackage

// File: rtl/rxdr_status_word.sv
// Builds the word-0 status value from the segment's flags.
// Assumes: the length is reported only in the last segment; bit 31 is left clear.
module rxdr_status_word
    import rxdr_pkg::*;
(
    input  rxdr_stat_t        st,
    output logic [WORD_W-1:0] word
);
    // compose the status fields
    always_comb begin
        word                      = '0;
        word[LEN_LSB +: LEN_W]    = st.last ? st.len : '0;
        word[FSEG_BIT]            = st.first;
        word[LSEG_BIT]            = st.last;
        word[OVF_BIT]             = st.ovf;
        word[CRC_BIT]             = st.crc;
        word[FTYPE_BIT]           = st.ftype;
        word[ESUM_BIT]            = st.crc | st.ovf;
    end
endmodule

// File: rtl/rxdr_byte_pack.sv
// Gathers stream bytes into one memory word, byte 0 in the lowest lane.
// Assumes: take and clear never come together; clear empties the word.
module rxdr_byte_pack
    import rxdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              clear,
    output logic [WORD_W-1:0] word,
    output logic [$clog2(WORD_BYTES)-1:0] lane
);
    localparam int LW = $clog2(WORD_BYTES);

    // place each accepted byte into its lane; empty after the word is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            lane <= '0;
        end else if (clear) begin
            word <= '0;
            lane <= '0;
        end else if (take) begin
            word[{lane, 3'b000} +: 8] <= byte_in;
            lane                      <= lane + LW'(1);
        end
    end

    // R2
    pack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !clear);
endmodule

// File: rtl/rxdr_drop_track.sv
// Follows frames that are dropped while the engine is suspended, and counts them.
// Assumes: active is high only in the suspended state.
module rxdr_drop_track #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          take,
    input  logic          is_last,
    output logic          dropping,
    output logic [CW-1:0] count
);
    // mark a frame in progress and count it when its last byte is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropping <= 1'b0;
            count    <= '0;
        end else if (active && take) begin
            dropping <= !is_last;
            if (is_last) count <= count + CW'(1);
        end
    end

    // R8
    miss_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && take && is_last) |=> count == $past(count) + CW'(1));
    // R8
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && take && is_last) |=> $stable(count));
endmodule

// File: rtl/rx_desc_ring_writer.sv
// Receive descriptor ring writer: stores stream frames into descriptor-owned buffers,
// writes status back to word 0 and moves round the ring.
// Assumes: ring of two or more descriptors; buffer sizes are multiples of 4 and size 1 is
// at least 4; buffer addresses word aligned; frames shorter than 2**14 bytes.
module rx_desc_ring_writer
    import rxdr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     ring_base,
    input  logic              poll_demand,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_crc_err,
    input  logic              in_fcs_incl,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CW-1:0]     missed_count
);
    localparam int LW = $clog2(WORD_BYTES);

    rxdr_state_e       state_q;
    logic [AW-1:0]     cur_q, wr_ptr_q, addr2_q;
    logic [SZ_W-1:0]   size1_q, size2_q;
    logic              wrap_q;
    logic [SEG_W-1:0]  seg_q;
    logic [LEN_W-1:0]  flen_q;
    logic              first_q, last_q, crc_q, ftype_q, ovf_q, poll_q;

    logic [AW-1:0]     next_desc;
    logic [SEG_W-1:0]  cap, seg_inc;
    logic              take, dropping, wd_clear;
    logic [WORD_W-1:0] pack_word, stat_word;
    logic [LW-1:0]     pack_lane;
    rxdr_stat_t        stat;
    logic              unused_rd;

    assign unused_rd = ^{mem_rdata[30:29], mem_rdata[14:13]};

    // address of the descriptor after the current one
    assign next_desc = wrap_q ? ring_base : cur_q + AW'(DESC_BYTES);
    // segment capacity and the count after one more byte
    assign cap     = {1'b0, size1_q} + {1'b0, size2_q};
    assign seg_inc = seg_q + SEG_W'(1);

    // stream acceptance per state
    always_comb begin
        case (state_q)
            ST_RECV, ST_DRAIN: in_ready = 1'b1;
            ST_SUSP:           in_ready = dropping || (start && !poll_q);
            default:           in_ready = 1'b0;
        endcase
    end
    assign take     = in_valid && in_ready;
    assign wd_clear = (state_q == ST_WRD) && mem_ack;

    rxdr_byte_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take && (state_q == ST_RECV)),
        .byte_in (in_data),
        .clear   (wd_clear),
        .word    (pack_word),
        .lane    (pack_lane)
    );

    rxdr_drop_track #(.CW(CW)) u_drop (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state_q == ST_SUSP),
        .take     (take),
        .is_last  (in_last),
        .dropping (dropping),
        .count    (missed_count)
    );

    assign stat = '{first: first_q, last: last_q, ovf: ovf_q, crc: crc_q,
                    ftype: ftype_q, len: flen_q};

    rxdr_status_word u_stat (
        .st   (stat),
        .word (stat_word)
    );

    // memory port drive per state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        case (state_q)
            ST_RD0:  mem_addr = cur_q;
            ST_RD1:  mem_addr = cur_q + AW'(4);
            ST_RD2:  mem_addr = cur_q + AW'(8);
            ST_RD3:  mem_addr = cur_q + AW'(12);
            ST_PEEK: mem_addr = next_desc;
            ST_WRD: begin
                mem_we    = 1'b1;
                mem_addr  = wr_ptr_q;
                mem_wdata = pack_word;
            end
            ST_WB: begin
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = stat_word;
            end
            default: mem_req = 1'b0;
        endcase
    end

    // latch a poll strobe until the suspended engine acts on it
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)
            poll_q <= 1'b0;
        else if (poll_demand)
            poll_q <= 1'b1;
        else if (state_q == ST_SUSP && !dropping)
            poll_q <= 1'b0;
    end

    // main sequencer: fetch, receive, write data, look ahead, write back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            wr_ptr_q <= '0;
            addr2_q  <= '0;
            size1_q  <= '0;
            size2_q  <= '0;
            wrap_q   <= 1'b0;
            seg_q    <= '0;
            flen_q   <= '0;
            first_q  <= 1'b1;
            last_q   <= 1'b0;
            crc_q    <= 1'b0;
            ftype_q  <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    cur_q   <= ring_base;
                    first_q <= 1'b1;
                    seg_q   <= '0;
                    flen_q  <= '0;
                    last_q  <= 1'b0;
                    crc_q   <= 1'b0;
                    ftype_q <= 1'b0;
                    ovf_q   <= 1'b0;
                    state_q <= ST_RD0;
                end
                ST_RD0: if (mem_ack)
                    state_q <= mem_rdata[OWN_BIT] ? ST_RD1 : ST_SUSP;
                ST_RD1: if (mem_ack) begin
                    size1_q <= mem_rdata[SZ1_LSB +: SZ_W];
                    size2_q <= mem_rdata[SZ2_LSB +: SZ_W];
                    wrap_q  <= mem_rdata[WRAP_BIT];
                    state_q <= ST_RD2;
                end
                ST_RD2: if (mem_ack) begin
                    wr_ptr_q <= AW'(mem_rdata);
                    state_q  <= ST_RD3;
                end
                ST_RD3: if (mem_ack) begin
                    addr2_q <= AW'(mem_rdata);
                    seg_q   <= '0;
                    state_q <= ST_RECV;
                end
                ST_SUSP: if (!dropping && (poll_q || !start))
                    state_q <= start ? ST_RD0 : ST_IDLE;
                ST_RECV: begin
                    if (take) begin
                        seg_q  <= seg_inc;
                        flen_q <= flen_q + LEN_W'(1);
                        if (in_last) begin
                            last_q  <= 1'b1;
                            crc_q   <= in_crc_err;
                            ftype_q <= in_fcs_incl;
                        end
                        if (pack_lane == LW'(WORD_BYTES - 1) || in_last || seg_inc == cap)
                            state_q <= ST_WRD;
                    end else if (!start && first_q && seg_q == '0) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WRD: if (mem_ack) begin
                    wr_ptr_q <= (seg_q == {1'b0, size1_q}) ? addr2_q
                                                          : wr_ptr_q + AW'(WORD_BYTES);
                    if (last_q)          state_q <= ST_WB;
                    else if (seg_q == cap) state_q <= ST_PEEK;
                    else                 state_q <= ST_RECV;
                end
                ST_PEEK: if (mem_ack) begin
                    if (!mem_rdata[OWN_BIT]) begin
                        ovf_q   <= 1'b1;
                        state_q <= ST_DRAIN;
                    end else begin
                        state_q <= ST_WB;
                    end
                end
                ST_DRAIN: if (take && in_last) begin
                    last_q  <= 1'b1;
                    crc_q   <= in_crc_err;
                    ftype_q <= in_fcs_incl;
                    state_q <= ST_WB;
                end
                ST_WB: if (mem_ack) begin
                    cur_q <= next_desc;
                    seg_q <= '0;
                    if (last_q) begin
                        first_q <= 1'b1;
                        flen_q  <= '0;
                        last_q  <= 1'b0;
                        crc_q   <= 1'b0;
                        ftype_q <= 1'b0;
                        ovf_q   <= 1'b0;
                    end else begin
                        first_q <= 1'b0;
                    end
                    state_q <= ST_RD0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata));
    // R4
    data_before_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB) |-> (pack_lane == '0));
    // R3
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV) |-> (seg_q < cap));
    // R5
    partial_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB && !last_q) |-> (seg_q == cap));
endmodule

// File: tb/sim_rx_desc_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_desc_ring_writer;
    localparam int AW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n, start, poll_demand;
    logic [AW-1:0] ring_base;
    logic in_valid, in_last, in_crc_err, in_fcs_incl, in_ready;
    logic [7:0] in_data;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [CW-1:0] missed_count;

    always #4 clk = ~clk;

    rx_desc_ring_writer #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
        .poll_demand(poll_demand), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_fcs_incl(in_fcs_incl),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .missed_count(missed_count)
    );

    // memory model with pseudo-random stalls
    logic [31:0] mem [0:1023];
    logic [7:0]  lf;
    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_ack   = mem_req && (lf[0] | lf[2]);
    always @(posedge clk) begin
        if (!rst_n) lf <= 8'h5A;
        else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct { logic [31:0] addr; logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    // scoreboard monitor: status writes and request hold
    logic prv_req = 0, prv_ack = 0, prv_we = 0;
    logic [31:0] prv_addr = 0, prv_wdata = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prv_req && !prv_ack) begin
                n_chk++;
                if (!(mem_req && mem_addr == prv_addr && mem_we == prv_we && mem_wdata == prv_wdata)) begin
                    n_bad++;
                    $display("FAIL R10 request changed while stalled: addr %h exp %h", mem_addr, prv_addr);
                end
            end
            if (mem_req && mem_we && mem_ack && mem_addr >= 32'h100 && mem_addr < 32'h180
                && mem_addr[4:0] == 5'd0) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8 unexpected status write: addr %h data %h exp none", mem_addr, mem_wdata);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (mem_addr != e.addr || mem_wdata != e.val) begin
                        n_bad++;
                        $display("FAIL %s status: addr %h data %h exp addr %h data %h",
                                 e.tag, mem_addr, mem_wdata, e.addr, e.val);
                    end
                end
            end
        end
        prv_req = mem_req && rst_n; prv_ack = mem_ack; prv_we = mem_we;
        prv_addr = mem_addr; prv_wdata = mem_wdata;
    end

    task automatic expect_st(input logic [31:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic chk_word(input logic [31:0] a, input logic [31:0] v, input string tag);
        chk(mem[a[11:2]] == v, tag, mem[a[11:2]], v);
    endtask

    // arm descriptor i: 8+8 byte buffers, wrap flag on descriptor 3
    task automatic arm(input int i);
        int w;
        w = (32'h100 + i * 32) >> 2;
        mem[w]     = 32'h8000_0000;
        mem[w + 1] = 32'd8 | (32'd8 << 16) | ((i == 3) ? 32'h8000 : 32'h0);
        mem[w + 2] = 32'h400 + i * 32'h40;
        mem[w + 3] = 32'h420 + i * 32'h40;
    endtask

    // driver: one frame, byte j = seed + j; optional poll strobe at byte poll_at
    task automatic send_frame(input int seed, input int len, input bit crc, input bit fcs, input int poll_at);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = 8'(seed + j);
            in_last     = (j == len - 1);
            in_crc_err  = crc && (j == len - 1);
            in_fcs_incl = fcs && (j == len - 1);
            poll_demand = (j == poll_at);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_fcs_incl = 1'b0; poll_demand = 1'b0;
    endtask

    task automatic wait_drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        rst_n = 0; start = 0; poll_demand = 0; ring_base = 32'h100;
        in_valid = 0; in_data = 0; in_last = 0; in_crc_err = 0; in_fcs_incl = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(mem_req == 1'b0, "R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
        chk(in_ready == 1'b0, "R1 in_ready after reset", {31'b0, in_ready}, 32'h0);
        chk(missed_count == '0, "R1 missed_count after reset", 32'(missed_count), 32'h0);

        arm(0); arm(1); arm(2);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        #1;
        chk(mem_req && !mem_we && mem_addr == 32'h100, "R1 first fetch at ring base", mem_addr, 32'h100);

        // frame A: 6 bytes in one buffer
        expect_st(32'h100, 32'h0006_0300, "R4");
        send_frame(8'h10, 6, 0, 0, -1);
        wait_drain();
        chk_word(32'h400, 32'h1312_1110, "R2 frame A word 0");
        chk_word(32'h404, 32'h0000_1514, "R2 frame A padded word");

        // frame B: spills into buffer 2, CRC error, frame-type marker
        expect_st(32'h120, 32'h000D_8322, "R4");
        send_frame(8'h20, 13, 1, 1, -1);
        wait_drain();
        chk_word(32'h444, 32'h2726_2524, "R3 frame B end of buffer 1");
        chk_word(32'h460, 32'h2B2A_2928, "R3 frame B buffer 2 word 0");
        chk_word(32'h464, 32'h0000_002C, "R3 frame B buffer 2 tail");

        // frame C: 20 bytes, next descriptor not armed -> overflow close
        expect_st(32'h140, 32'h0010_8B00, "R6");
        send_frame(8'h40, 20, 0, 0, -1);
        wait_drain();
        chk_word(32'h480, 32'h4342_4140, "R6 frame C first word");
        chk_word(32'h4A4, 32'h4F4E_4D4C, "R6 frame C last stored word");
        chk_word(32'h4C0, 32'h0000_0000, "R6 discarded bytes not stored");

        // frame D: engine suspended on descriptor 3 -> dropped
        send_frame(8'h50, 5, 0, 0, -1);
        repeat (10) @(negedge clk);
        chk(missed_count == 16'd1, "R8 missed after one drop", 32'(missed_count), 32'd1);

        // arm 3 and 0, poll; frame E splits across the wrap
        arm(3); arm(0);
        @(negedge clk); poll_demand = 1; @(negedge clk); poll_demand = 0;
        expect_st(32'h160, 32'h0000_0200, "R5");
        expect_st(32'h100, 32'h001E_0100, "R7");
        send_frame(8'h60, 30, 0, 0, -1);
        wait_drain();
        chk_word(32'h4C0, 32'h6362_6160, "R5 frame E first segment");
        chk_word(32'h4E4, 32'h6F6E_6D6C, "R5 frame E first segment tail");
        chk_word(32'h400, 32'h7372_7170, "R7 frame E after wrap");
        chk_word(32'h424, 32'h0000_7D7C, "R7 frame E last word");

        // frame F: poll arrives mid-drop, frame still dropped whole
        arm(1); arm(2);
        send_frame(8'h80, 8, 0, 0, 3);
        repeat (10) @(negedge clk);
        chk(missed_count == 16'd2, "R9 frame dropped whole despite poll", 32'(missed_count), 32'd2);
        expect_st(32'h120, 32'h0004_0300, "R9");
        send_frame(8'h90, 4, 0, 0, -1);
        wait_drain();
        chk_word(32'h440, 32'h9392_9190, "R9 frame after poll stored");

        // park and restart from ring base
        repeat (20) @(negedge clk);
        start = 0;
        repeat (6) @(negedge clk);
        #1;
        chk(!in_ready && !mem_req, "R11 parked", {30'b0, in_ready, mem_req}, 32'h0);
        arm(0);
        @(negedge clk);
        start = 1;
        expect_st(32'h100, 32'h0003_0300, "R11");
        send_frame(8'hA0, 3, 0, 0, -1);
        wait_drain();
        chk_word(32'h400, 32'h00A2_A1A0, "R11 restart data at ring base");
        chk_word(32'h140, 32'h8000_0000, "R11 descriptor 2 untouched");
        chk(exp_q.size() == 0, "R4 all expected status seen", 32'(exp_q.size()), 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule